// File: doc/BRIEF.md
# Toggle-Based Request/Acknowledge Handshake

This block joins a requesting agent and a responding agent with two single-bit lines, `reqLine` and `ackLine`. The lines use a two-phase handshake. The requester starts a transaction by inverting `reqLine`. The responder signals that the transaction is finished by inverting `ackLine`. The interface is idle whenever the two lines hold the same value.

No pulse has to be caught by the far side, and a level left asserted cannot start a second job. The two sides may run on clocks whose rising edges are aligned, with the responder clock an integer multiple of the requester clock.

On the requester side, the command level may still be settling early in the cycle. It is captured on the falling edge of the requester clock, half a cycle after it was driven. Its rising edge then becomes a one-cycle launch strobe, and that strobe steers the inverted request into the request register. While a transaction is open, `busy` is high and any new command edge is discarded.

On the responder side, the incoming request is compared with a stored copy of the last request it served. When the two differ, the responder runs a stub job whose latency comes from the `jobLatency` input. At the end of the job it inverts `ackLine`.

Top module: `toggle_handshake`

## Requirements
- R1: While `rstN` is low, and after its release until the first command, `reqLine`, `ackLine`, `busy` and `jobActive` are all 0.
- R2: `cmdRaw` is captured only on the falling edge of `clkReq`. A high glitch that starts and ends within the high phase of `clkReq` starts no transaction, and `reqLine` stays unchanged.
- R3: A 0-to-1 change of the captured command, while idle, inverts `reqLine` at the next rising edge of `clkReq`. Holding `cmdRaw` high starts exactly one transaction.
- R4: `busy` is 1 exactly when `reqLine` differs from `ackLine`. It rises only because `reqLine` was inverted.
- R5: A command edge that arrives while `busy` is 1 is rejected. `reqLine` is not inverted again for it, either during or after the open transaction.
- R6: The responder detects a request by comparing `reqLine` with its last-served copy. It inverts `ackLine` exactly L+2 rising `clkRsp` edges after `reqLine` was inverted, where L is `jobLatency` taken at detection. `ackLine` changes only while a transaction is open.
- R7: `jobActive` is high for exactly L+1 `clkRsp` cycles per transaction, and only while `reqLine` differs from `ackLine`.
- R8: A transaction completes when `ackLine` equals `reqLine`. Successive transactions alternate the polarity of `reqLine`, so the second one drives it from 1 back to 0.
- R9: R3 to R8 hold when `clkRsp` is an integer multiple (three in the bench) of `clkReq` with aligned rising edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clkReq | input | 1 | Requester clock |
| clkRsp | input | 1 | Responder clock, an integer multiple of `clkReq`, with aligned rising edges |
| rstN | input | 1 | Asynchronous reset for both sides, active low |
| cmdRaw | input | 1 | Raw command level, which may glitch early in the `clkReq` cycle |
| jobLatency | input | LAT_W | Extra responder cycles for the stub job |
| reqLine | output | 1 | Toggling request line |
| ackLine | output | 1 | Toggling acknowledge line |
| busy | output | 1 | Transaction open (`reqLine` differs from `ackLine`) |
| jobActive | output | 1 | Responder stub job in progress |

## Verification
Every latency from 0 to 15 is run as a back-to-back series. This separates an off-by-one in the countdown from an error in detection, and it shows that the request polarity alternates. A glitch that settles before the capture edge is set against a glitch that dies before it, which tells mid-cycle capture apart from sampling on the launching edge. A command held high, and a second command edge raised inside a long job, tell edge-based launch from level-based launch and show that rejection while busy works.

// File: rtl/hs_pkg.sv
`timescale 1ns/1ps
package hs_pkg;
  // Strobes from responder control to responder datapath
  typedef struct packed {
    logic capture;    // latch request copy, load latency, start job
    logic countDown;  // one job cycle elapsed
    logic flipAck;    // job finished: invert acknowledge
  } rspStrobe_t;
endpackage

// File: rtl/hs_requester.sv
`timescale 1ns/1ps
module hs_requester (
  input  logic clkReq,
  input  logic rstN,
  input  logic cmdRaw,
  input  logic ackLine,
  output logic reqLine,
  output logic busy
);
  logic cmdMid;
  logic cmdSeen;
  logic reqQ;
  logic cmdPulse;
  logic idle;
  logic launch;
  logic reqNext;

  // mid-cycle capture of the possibly unsettled command
  always_ff @(negedge clkReq or negedge rstN) begin
    if (!rstN) cmdMid <= 1'b0;
    else       cmdMid <= cmdRaw;
  end

  always_comb begin
    cmdPulse = cmdMid & ~cmdSeen;
    idle     = (reqQ == ackLine);
    launch   = cmdPulse & idle;
    reqNext  = launch ? ~reqQ : reqQ;
  end

  always_ff @(posedge clkReq or negedge rstN) begin
    if (!rstN) begin
      cmdSeen <= 1'b0;
      reqQ    <= 1'b0;
    end else begin
      cmdSeen <= cmdMid;
      reqQ    <= reqNext;
    end
  end

  assign reqLine = reqQ;
  assign busy    = ~idle;
endmodule

// File: rtl/hs_rsp_ctrl.sv
`timescale 1ns/1ps
module hs_rsp_ctrl
  import hs_pkg::*;
(
  input  logic       reqLine,
  input  logic       reqSeen,
  input  logic       active,
  input  logic       cntZero,
  output rspStrobe_t stb
);
  always_comb begin
    stb.capture   = ~active & (reqLine != reqSeen);
    stb.countDown = active & ~cntZero;
    stb.flipAck   = active & cntZero;
  end
endmodule

// File: rtl/hs_rsp_dp.sv
`timescale 1ns/1ps
module hs_rsp_dp
  import hs_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clkRsp,
  input  logic             rstN,
  input  rspStrobe_t       stb,
  input  logic             reqLine,
  input  logic [LAT_W-1:0] jobLatency,
  output logic             reqSeen,
  output logic             active,
  output logic             cntZero,
  output logic             ackLine
);
  logic [LAT_W-1:0] cnt;

  always_ff @(posedge clkRsp or negedge rstN) begin
    if (!rstN) begin
      reqSeen <= 1'b0;
      active  <= 1'b0;
      cnt     <= '0;
      ackLine <= 1'b0;
    end else if (stb.capture) begin
      reqSeen <= reqLine;
      cnt     <= jobLatency;
      active  <= 1'b1;
    end else if (stb.countDown) begin
      cnt <= cnt - 1'b1;
    end else if (stb.flipAck) begin
      ackLine <= ~ackLine;
      active  <= 1'b0;
    end
  end

  assign cntZero = (cnt == '0);
endmodule

// File: rtl/toggle_handshake.sv
`timescale 1ns/1ps
module toggle_handshake
  import hs_pkg::*;
#(
  parameter int LAT_W = 4
) (
  input  logic             clkReq,
  input  logic             clkRsp,
  input  logic             rstN,
  input  logic             cmdRaw,
  input  logic [LAT_W-1:0] jobLatency,
  output logic             reqLine,
  output logic             ackLine,
  output logic             busy,
  output logic             jobActive
);
  rspStrobe_t stb;
  logic reqSeen;
  logic cntZero;

  hs_requester u_req (
    .clkReq (clkReq),
    .rstN   (rstN),
    .cmdRaw (cmdRaw),
    .ackLine(ackLine),
    .reqLine(reqLine),
    .busy   (busy)
  );

  hs_rsp_ctrl u_ctrl (
    .reqLine(reqLine),
    .reqSeen(reqSeen),
    .active (jobActive),
    .cntZero(cntZero),
    .stb    (stb)
  );

  hs_rsp_dp #(.LAT_W(LAT_W)) u_dp (
    .clkRsp    (clkRsp),
    .rstN      (rstN),
    .stb       (stb),
    .reqLine   (reqLine),
    .jobLatency(jobLatency),
    .reqSeen   (reqSeen),
    .active    (jobActive),
    .cntZero   (cntZero),
    .ackLine   (ackLine)
  );
endmodule

// File: rtl/hs_checker.sv
`timescale 1ns/1ps
module hs_checker (
  input logic clkReq,
  input logic clkRsp,
  input logic rstN,
  input logic reqLine,
  input logic ackLine,
  input logic busy,
  input logic jobActive
);
  // R1: idle lines while held in reset
  always @(posedge clkReq) begin
    if (!rstN) begin
      a_r1_reset_idle: assert (!reqLine && !ackLine && !busy && !jobActive);
    end
  end

  // R5: request inverts only when the lines matched at the launching edge
  a_r5_req_flip_only_idle: assert property (@(posedge clkRsp) disable iff (!rstN)
    (reqLine != $past(reqLine)) |-> $past(reqLine == ackLine));

  // R6: acknowledge inverts only while a transaction is open
  a_r6_ack_flip_only_open: assert property (@(posedge clkRsp) disable iff (!rstN)
    (ackLine != $past(ackLine)) |-> $past(reqLine != ackLine));

  // R7: stub job runs only inside an open transaction
  a_r7_active_in_open: assert property (@(posedge clkRsp) disable iff (!rstN)
    jobActive |-> (reqLine != ackLine));

  // R4: busy rises only together with a request inversion
  a_r4_busy_rise_cause: assert property (@(posedge clkRsp) disable iff (!rstN)
    $rose(busy) |-> (reqLine != $past(reqLine)));
endmodule

bind toggle_handshake hs_checker u_chk (
  .clkReq   (clkReq),
  .clkRsp   (clkRsp),
  .rstN     (rstN),
  .reqLine  (reqLine),
  .ackLine  (ackLine),
  .busy     (busy),
  .jobActive(jobActive)
);

// File: tb/toggle_handshake_tb.sv
`timescale 1ns/1ps
module toggle_handshake_tb;
  localparam int LAT_W = 4;
  localparam int RATIO = 3;

  logic clkReq, clkRsp, rstN, cmdRaw;
  logic [LAT_W-1:0] jobLatency;
  logic reqLine, ackLine, busy, jobActive;

  int nChecks = 0;
  int nFails  = 0;
  int phase   = 0;

  toggle_handshake #(.LAT_W(LAT_W)) u_dut (
    .clkReq(clkReq), .clkRsp(clkRsp), .rstN(rstN), .cmdRaw(cmdRaw),
    .jobLatency(jobLatency), .reqLine(reqLine), .ackLine(ackLine),
    .busy(busy), .jobActive(jobActive)
  );

  // 200 MHz responder clock; requester clock RATIO times slower, rising edges aligned
  initial begin
    clkReq = 0;
    clkRsp = 0;
    forever begin
      #2.5;
      phase++;
      clkRsp = ~clkRsp;
      if (phase % RATIO == 0) clkReq = ~clkReq;
    end
  end

  // Monitor sampled at falling responder edges (outputs move on rising edges only)
  logic lastReq = 0, lastAck = 0;
  int reqToggles = 0, ackToggles = 0, lat = 0, measLat = -1, activeCnt = 0;
  bit measuring = 0;
  always @(negedge clkRsp) begin
    if (jobActive) activeCnt++;
    if (ackLine != lastAck) ackToggles++;
    if (reqLine != lastReq) begin
      reqToggles++;
      lat = 0;
      measuring = 1;
    end else if (measuring) begin
      lat++;
      if (ackLine != lastAck) begin
        measLat = lat;
        measuring = 0;
      end
    end
    lastReq = reqLine;
    lastAck = ackLine;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    reqToggles = 0; ackToggles = 0; measLat = -1; activeCnt = 0; measuring = 0;
  endtask

  task automatic waitIdle();
    for (int i = 0; i < 400; i++) begin
      @(negedge clkRsp);
      if (reqToggles > 0 && !busy) break;
    end
  endtask

  task automatic reqCycles(input int n);
    for (int i = 0; i < n; i++) @(posedge clkReq);
    #1;
  endtask

  bit done = 0;
  initial begin
    #(200000 * 5);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    rstN = 0;
    cmdRaw = 0;
    jobLatency = '0;
    reqCycles(4);
    // R1 during reset
    check(!reqLine && !ackLine, "R1 lines in reset", {reqLine, ackLine}, 0);
    check(!busy && !jobActive, "R1 busy/active in reset", {busy, jobActive}, 0);
    rstN = 1;
    reqCycles(3);
    check(!reqLine && !ackLine && !busy, "R1 idle after release", {reqLine, ackLine, busy}, 0);

    // R2: glitch that dies before the falling edge is ignored
    clearMon();
    cmdRaw = 1; #1; cmdRaw = 0;
    reqCycles(6);
    check(reqToggles == 0, "R2 short glitch ignored", reqToggles, 0);
    check(!busy, "R2 busy after glitch", busy, 0);

    // R2/R3: glitchy early level that settles high launches one transaction
    clearMon();
    jobLatency = 4'd3;
    cmdRaw = 1; #1; cmdRaw = 0; #1; cmdRaw = 1;
    @(posedge clkReq); #1;
    check(reqLine == 1'b1, "R3 req inverted at next rising edge", reqLine, 1);
    check(busy, "R4 busy while open", busy, 1);
    waitIdle();
    reqCycles(10);
    check(reqToggles == 1, "R3 held level starts one transaction", reqToggles, 1);
    check(ackLine == reqLine && !busy, "R8 complete when lines match", ackLine, reqLine);
    cmdRaw = 0;
    reqCycles(2);

    // R5: second command edge inside a long job is rejected
    clearMon();
    jobLatency = 4'd15;
    cmdRaw = 1;
    reqCycles(2);
    cmdRaw = 0;
    reqCycles(1);
    check(busy, "R5 still open at second edge", busy, 1);
    cmdRaw = 1;
    waitIdle();
    reqCycles(10);
    check(reqToggles == 1, "R5 rejected command did not launch", reqToggles, 1);
    check(measLat == 17, "R6 latency at max", measLat, 17);
    cmdRaw = 0;
    reqCycles(2);

    // R6/R7/R8/R9: latency sweep, back to back, alternating polarity
    for (int L = 0; L < 16; L++) begin
      logic startReq;
      startReq = reqLine;
      jobLatency = LAT_W'(L);
      clearMon();
      cmdRaw = 1;
      waitIdle();
      reqCycles(1);
      cmdRaw = 0;
      reqCycles(2);
      check(measLat == L + 2, $sformatf("R6 R9 ack latency L=%0d", L), measLat, L + 2);
      check(activeCnt == L + 1, $sformatf("R7 job cycles L=%0d", L), activeCnt, L + 1);
      check(reqToggles == 1 && ackToggles == 1, $sformatf("R8 one toggle each L=%0d", L),
            reqToggles * 10 + ackToggles, 11);
      check(reqLine == ~startReq && !busy, $sformatf("R8 polarity alternates L=%0d", L),
            reqLine, ~startReq);
    end

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule